// File: doc/BRIEF.md
# Destination Register Renamer with Pinned Write Runs

This block renames architectural destination registers onto a larger pool of physical registers. A map table holds the current physical tag of every architectural register, and a first-in first-out free list supplies new tags. A source lookup port reads the map combinationally. A writeback port marks physical registers ready. A release port hands retired tags back to the free list.

A rename may carry a pin count N. This says that N consecutive writes, for example micro-ops that each fill a separate slice of one wide register, share a single physical register. The first rename of the run takes a fresh tag. The next N-1 renames of the same architectural register reuse that tag and draw nothing from the free list. The shared register becomes ready only after all N partial writebacks have landed, in any order.

A squash port undoes the youngest rename held in a short history stack. Undoing a fresh allocation restores the old mapping and returns the tag. Undoing a reuse gives back one reuse and, when that write had already landed, one pending writeback, so the run can be renamed again with correct counts. Each cycle is decoded into one of five operations: OP_IDLE (nothing requested), OP_SQUASH (squash present, which wins over any rename), OP_REUSE (rename inside a pinned run), OP_ALLOC (rename taking a fresh tag) and OP_STALL (fresh tag needed but the free list is empty). The transitions are purely per cycle, so there is no stored state: the decision order is squash, then idle, then reuse, then stall, then alloc.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers 0 to 15 read ready and 16 to 31 read not ready, none is flagged pinned, and stall is low.
- R2: A rename that is not inside a pinned run takes the head of the free list, which starts as 16, 17, 18 and so on in FIFO order. It raises ren_ok in the same cycle, reports the old mapping on ren_prev_phys, and clears the ready flag of the new tag.
- R3: A fresh rename with pin count N>0 opens a run of N renames that share one tag. The next N-1 renames of the same architectural register return that tag with ren_reused=1, ignore their own pin field and take no free-list entry. The rename after the run allocates afresh.
- R4: phys_pinned of a tag is set by a fresh rename with nonzero pin count and cleared by one with pin count zero. It stays set after the run's reuses are used up.
- R5: An unpinned tag reads ready in the cycle after its single writeback. A tag allocated with pin count N reads ready only after N writebacks, and not after N-1.
- R6: src_phys shows the mapping of src_arch as left by all renames and squashes of earlier cycles.
- R7: Squashing a fresh allocation restores the previous mapping and appends the freed tag to the tail of the free list.
- R8: Squashing a reuse grants one more reuse of that tag. When sq_landed is high, one more writeback is also required before the tag reads ready.
- R9: When squash and rename arrive in the same cycle, the squash is carried out and the rename is dropped: ren_ok and ren_stall stay low.
- R10: A rename that needs a fresh tag while the free list is empty raises ren_stall, leaves ren_ok low and changes no mapping. A reuse still proceeds while the list is empty.
- R11: A release appends rel_phys to the tail of the free list, so it can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | 4 | Architectural destination |
| ren_pin | input | 4 | Pin count, 0 means unpinned |
| src_arch | input | 4 | Source register to look up |
| wb_valid | input | 1 | Writeback strobe |
| wb_phys | input | 5 | Tag written back |
| sq_valid | input | 1 | Undo youngest rename |
| sq_landed | input | 1 | The squashed write had already been written back |
| rel_valid | input | 1 | Release strobe |
| rel_phys | input | 5 | Tag returned to the free list |
| ren_ok | output | 1 | Rename accepted this cycle |
| ren_stall | output | 1 | Rename blocked, free list empty |
| ren_phys | output | 5 | Tag given to the destination |
| ren_prev_phys | output | 5 | Mapping before this rename |
| ren_reused | output | 1 | Tag reused inside a pinned run |
| src_phys | output | 5 | Current mapping of src_arch |
| phys_ready | output | 32 | Ready flag per physical register |
| phys_pinned | output | 32 | Pinned flag per physical register |

## Verification
The squash and rename ports can both fire in one cycle. The bench provokes this with a rename request raised alongside a squash right after a fresh allocation. It judges the outcome by ren_ok and ren_stall staying low, and by src_phys reverting to the older tag in the next cycle. The free list then hands out the next head rather than the squashed tag, which confirms that the dropped rename consumed nothing. A squash of a reused write, with and without sq_landed, is followed by writebacks and a re-rename, to show that the reuse and pending counts were rebuilt.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SQUASH,
        OP_REUSE,
        OP_ALLOC,
        OP_STALL
    } op_e;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int DEPTH = 32,
    parameter int FIRST = 16,
    parameter int INIT  = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop,
    input  logic            push_a,
    input  logic [PW-1:0]   data_a,
    input  logic            push_b,
    input  logic [PW-1:0]   data_b,
    output logic [PW-1:0]   head_data,
    output logic            empty,
    output logic [CNTW-1:0] count
);
    logic [PW-1:0]   mem [DEPTH];
    logic [PW-1:0]   head_q, tail_q;
    logic [CNTW-1:0] cnt_q;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [PW-1:0] tail_b;
    assign tail_b    = push_a ? nxt(tail_q) : tail_q;
    assign head_data = mem[head_q];
    assign empty     = (cnt_q == '0);
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++)
                mem[j] <= (j < INIT) ? PW'(FIRST + j) : '0;
            head_q <= '0;
            tail_q <= PW'(INIT % DEPTH);
            cnt_q  <= CNTW'(INIT);
        end else begin
            if (push_a) mem[tail_q] <= data_a;
            if (push_b) mem[tail_b] <= data_b;
            tail_q <= push_b ? nxt(tail_b) : tail_b;
            if (pop) head_q <= nxt(head_q);
            cnt_q <= cnt_q + CNTW'(push_a) + CNTW'(push_b) - CNTW'(pop);
        end
    end

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt_q) + 32'(push_a) + 32'(push_b) - 32'(pop)) <= 32'(DEPTH)); // R11
endmodule

// File: rtl/rn_history.sv
module rn_history #(
    parameter int W = 15,
    parameter int H = 8,
    localparam int HW = $clog2(H + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] top_data,
    output logic         top_valid
);
    logic [W-1:0]  ent_q [H];
    logic [HW-1:0] cnt_q;

    assign top_data  = ent_q[0];
    assign top_valid = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < H; k++) ent_q[k] <= '0;
            cnt_q <= '0;
        end else if (push) begin
            ent_q[0] <= push_data;
            for (int k = 1; k < H; k++) ent_q[k] <= ent_q[k-1];
            if (cnt_q != HW'(H)) cnt_q <= cnt_q + 1'b1;
        end else if (pop && top_valid) begin
            for (int k = 0; k < H - 1; k++) ent_q[k] <= ent_q[k+1];
            ent_q[H-1] <= '0;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R9
endmodule

// File: rtl/rn_regstate.sv
module rn_regstate #(
    parameter int NUM_PHYS = 32,
    parameter int NUM_ARCH = 16,
    parameter int CW       = 4,
    localparam int PW      = $clog2(NUM_PHYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_en,
    input  logic [PW-1:0]                 alloc_p,
    input  logic [CW-1:0]                 alloc_pin,
    input  logic                          reuse_en,
    input  logic [PW-1:0]                 reuse_p,
    input  logic                          wb_en,
    input  logic [PW-1:0]                 wb_p,
    input  logic                          sqr_en,
    input  logic                          sqf_en,
    input  logic [PW-1:0]                 sq_p,
    input  logic                          sq_landed,
    output logic [NUM_PHYS-1:0][CW-1:0]   rem_o,
    output logic [NUM_PHYS-1:0]           ready_o,
    output logic [NUM_PHYS-1:0]           pinned_o
);
    for (genvar i = 0; i < NUM_PHYS; i++) begin : g_reg
        logic [CW-1:0] rem_q, pend_q, pend_n;
        logic          pin_q, rdy_q;
        logic          a_hit, u_hit, w_hit, sr_hit, sf_hit, dec, inc;

        assign a_hit  = alloc_en && (alloc_p == PW'(i));
        assign u_hit  = reuse_en && (reuse_p == PW'(i));
        assign w_hit  = wb_en && (wb_p == PW'(i));
        assign sr_hit = sqr_en && (sq_p == PW'(i));
        assign sf_hit = sqf_en && (sq_p == PW'(i));
        assign dec    = w_hit && (pend_q != '0);
        assign inc    = sr_hit && sq_landed;
        assign pend_n = pend_q + CW'(inc) - CW'(dec);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rem_q  <= '0;
                pend_q <= '0;
                pin_q  <= 1'b0;
                rdy_q  <= (i < NUM_ARCH);
            end else if (a_hit) begin
                rem_q  <= (alloc_pin == '0) ? '0 : alloc_pin - 1'b1;
                pend_q <= (alloc_pin == '0) ? CW'(1) : alloc_pin;
                pin_q  <= (alloc_pin != '0);
                rdy_q  <= 1'b0;
            end else if (sf_hit) begin
                rem_q  <= '0;
                pend_q <= '0;
                pin_q  <= 1'b0;
                rdy_q  <= 1'b0;
            end else begin
                rem_q  <= rem_q + CW'(sr_hit) - CW'(u_hit);
                pend_q <= pend_n;
                if (w_hit || inc) rdy_q <= (pend_n == '0);
            end
        end

        assign rem_o[i]    = rem_q;
        assign ready_o[i]  = rdy_q;
        assign pinned_o[i] = pin_q;

        AST_PIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_q && !a_hit && !sf_hit) |=> pin_q); // R4
        AST_READY_ALL_LANDED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy_q) |-> (pend_q == '0)); // R5
        AST_NO_REUSE_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            u_hit |-> (rem_q != '0)); // R3
    end
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit
    import rn_pkg::*;
#(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 32,
    parameter int CW       = 4,
    parameter int HIST     = 8,
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int HEW     = AW + 2 * PW + 1,
    localparam int CNTW    = $clog2(NUM_PHYS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ren_valid,
    input  logic [AW-1:0]       ren_arch,
    input  logic [CW-1:0]       ren_pin,
    input  logic [AW-1:0]       src_arch,
    input  logic                wb_valid,
    input  logic [PW-1:0]       wb_phys,
    input  logic                sq_valid,
    input  logic                sq_landed,
    input  logic                rel_valid,
    input  logic [PW-1:0]       rel_phys,
    output logic                ren_ok,
    output logic                ren_stall,
    output logic [PW-1:0]       ren_phys,
    output logic [PW-1:0]       ren_prev_phys,
    output logic                ren_reused,
    output logic [PW-1:0]       src_phys,
    output logic [NUM_PHYS-1:0] phys_ready,
    output logic [NUM_PHYS-1:0] phys_pinned
);
    typedef struct packed {
        logic [AW-1:0] arch;
        logic [PW-1:0] newp;
        logic [PW-1:0] prevp;
        logic          reused;
    } hist_t;

    logic [NUM_ARCH-1:0][PW-1:0] map_q;
    logic [NUM_PHYS-1:0][CW-1:0] rem_vec;
    logic [PW-1:0]   cur_p, fl_head;
    logic            fl_empty, can_reuse, h_valid;
    logic [CNTW-1:0] fl_count;
    logic [HEW-1:0]  h_raw;
    hist_t           h_top, h_new;
    logic            sq_do, sq_fresh, sq_reuse;
    op_e             op;

    assign cur_p     = map_q[ren_arch];
    assign can_reuse = (rem_vec[cur_p] != '0);
    assign src_phys  = map_q[src_arch];
    assign h_top     = hist_t'(h_raw);

    always_comb begin
        if (sq_valid)        op = OP_SQUASH;
        else if (!ren_valid) op = OP_IDLE;
        else if (can_reuse)  op = OP_REUSE;
        else if (fl_empty)   op = OP_STALL;
        else                 op = OP_ALLOC;
    end

    always_comb begin
        ren_ok     = 1'b0;
        ren_stall  = 1'b0;
        ren_reused = 1'b0;
        ren_phys   = fl_head;
        unique case (op)
            OP_IDLE:   ;
            OP_SQUASH: ;
            OP_REUSE: begin
                ren_ok     = 1'b1;
                ren_reused = 1'b1;
                ren_phys   = cur_p;
            end
            OP_ALLOC:  ren_ok    = 1'b1;
            OP_STALL:  ren_stall = 1'b1;
        endcase
    end
    assign ren_prev_phys = cur_p;

    assign sq_do    = (op == OP_SQUASH) && h_valid;
    assign sq_fresh = sq_do && !h_top.reused;
    assign sq_reuse = sq_do && h_top.reused;

    always_comb begin
        h_new.arch   = ren_arch;
        h_new.newp   = ren_phys;
        h_new.prevp  = cur_p;
        h_new.reused = ren_reused;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
        end else if (op == OP_ALLOC) begin
            map_q[ren_arch] <= fl_head;
        end else if (sq_fresh) begin
            map_q[h_top.arch] <= h_top.prevp;
        end
    end

    rn_freelist #(.DEPTH(NUM_PHYS), .FIRST(NUM_ARCH), .INIT(NUM_PHYS - NUM_ARCH)) u_fl (
        .clk(clk), .rst_n(rst_n),
        .pop(op == OP_ALLOC),
        .push_a(sq_fresh), .data_a(h_top.newp),
        .push_b(rel_valid), .data_b(rel_phys),
        .head_data(fl_head), .empty(fl_empty), .count(fl_count)
    );

    rn_history #(.W(HEW), .H(HIST)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .push(ren_ok), .push_data(h_new),
        .pop(sq_valid),
        .top_data(h_raw), .top_valid(h_valid)
    );

    rn_regstate #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .CW(CW)) u_rs (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(op == OP_ALLOC), .alloc_p(fl_head), .alloc_pin(ren_pin),
        .reuse_en(op == OP_REUSE), .reuse_p(cur_p),
        .wb_en(wb_valid), .wb_p(wb_phys),
        .sqr_en(sq_reuse), .sqf_en(sq_fresh), .sq_p(h_top.newp),
        .sq_landed(sq_landed),
        .rem_o(rem_vec), .ready_o(phys_ready), .pinned_o(phys_pinned)
    );

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ren_stall |=> $stable(map_q)); // R10
    AST_SQUASH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> (!ren_ok && !ren_stall)); // R9
    AST_REUSE_NO_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_reused && !rel_valid) |=> $stable(fl_count)); // R3
    AST_ALLOC_HAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_ok && !ren_reused) |-> !fl_empty); // R2
endmodule

// File: tb/sim_rn_rename_unit.sv
module sim_rn_rename_unit;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ren_valid = 0, wb_valid = 0, sq_valid = 0, sq_landed = 0, rel_valid = 0;
    logic [3:0] ren_arch = 0, ren_pin = 0, src_arch = 0;
    logic [4:0] wb_phys = 0, rel_phys = 0;
    logic ren_ok, ren_stall, ren_reused;
    logic [4:0] ren_phys, ren_prev_phys, src_phys;
    logic [31:0] phys_ready, phys_pinned;
    int errors = 0, checks = 0;

    always #2 clk = ~clk;

    rn_rename_unit u0 (.*);

    typedef struct packed {
        logic rv; logic [3:0] ra; logic [3:0] pin; logic sq; logic [3:0] sa;
        logic eok; logic est; logic [4:0] ep; logic eru; logic [4:0] es;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{1'b1, 4'd3, 4'd0, 1'b0, 4'd3, 1'b1, 1'b0, 5'd16, 1'b0, 5'd3},
        '{1'b1, 4'd3, 4'd3, 1'b0, 4'd3, 1'b1, 1'b0, 5'd17, 1'b0, 5'd16},
        '{1'b1, 4'd3, 4'd0, 1'b0, 4'd3, 1'b1, 1'b0, 5'd17, 1'b1, 5'd17},
        '{1'b1, 4'd3, 4'd5, 1'b0, 4'd3, 1'b1, 1'b0, 5'd17, 1'b1, 5'd17},
        '{1'b1, 4'd3, 4'd0, 1'b0, 4'd3, 1'b1, 1'b0, 5'd18, 1'b0, 5'd17},
        '{1'b1, 4'd5, 4'd2, 1'b1, 4'd3, 1'b0, 1'b0, 5'd0,  1'b0, 5'd18},
        '{1'b1, 4'd3, 4'd0, 1'b0, 4'd3, 1'b1, 1'b0, 5'd19, 1'b0, 5'd17},
        '{1'b0, 4'd0, 4'd0, 1'b1, 4'd3, 1'b0, 1'b0, 5'd0,  1'b0, 5'd19},
        '{1'b0, 4'd0, 4'd0, 1'b1, 4'd3, 1'b0, 1'b0, 5'd0,  1'b0, 5'd17},
        '{1'b1, 4'd3, 4'd0, 1'b0, 4'd3, 1'b1, 1'b0, 5'd17, 1'b1, 5'd17},
        '{1'b1, 4'd7, 4'd0, 1'b0, 4'd7, 1'b1, 1'b0, 5'd20, 1'b0, 5'd7}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ren_valid = 0; sq_valid = 0; sq_landed = 0; wb_valid = 0; rel_valid = 0;
    endtask

    task automatic wb(input logic [4:0] p);
        wb_valid = 1; wb_phys = p;
        step();
    endtask

    task automatic ren(input logic [3:0] a, input logic [3:0] pin);
        ren_valid = 1; ren_arch = a; ren_pin = pin; #1;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 ready", phys_ready, 32'h0000FFFF);
        chk("R1 pinned", phys_pinned, 32'h0);
        chk("R1 stall", 32'(ren_stall), 0);
        for (int i = 0; i < 16; i++) begin
            src_arch = 4'(i); #1;
            chk("R1 map", 32'(src_phys), 32'(i));
        end
        @(negedge clk);

        // table walk: rename, pinned run, squash priority, squash undo
        for (int v = 0; v < 11; v++) begin
            ren_valid = VEC[v].rv; ren_arch = VEC[v].ra; ren_pin = VEC[v].pin;
            sq_valid = VEC[v].sq; src_arch = VEC[v].sa; #1;
            chk(VEC[v].sq ? "R9 ok" : "R2 ok", 32'(ren_ok), 32'(VEC[v].eok));
            chk(VEC[v].sq ? "R9 stall" : "R10 stall", 32'(ren_stall), 32'(VEC[v].est));
            if (VEC[v].eok) begin
                chk(VEC[v].eru ? "R3 tag" : "R2 tag", 32'(ren_phys), 32'(VEC[v].ep));
                chk("R3 reused", 32'(ren_reused), 32'(VEC[v].eru));
            end
            chk("R6 src", 32'(src_phys), 32'(VEC[v].es));
            step();
        end

        // R4 pinned flags: 17 pinned with run exhausted, 16 and 20 unpinned
        chk("R4 pinned17", 32'(phys_pinned[17]), 1);
        chk("R4 pinned16", 32'(phys_pinned[16]), 0);
        chk("R4 pinned20", 32'(phys_pinned[20]), 0);
        // R5 pinned with three outstanding writes
        wb(5'd17); wb(5'd17);
        chk("R5 not after N-1", 32'(phys_ready[17]), 0);
        wb(5'd17);
        chk("R5 ready after N", 32'(phys_ready[17]), 1);
        chk("R5 unpinned before wb", 32'(phys_ready[20]), 0);
        wb(5'd20);
        chk("R5 unpinned after wb", 32'(phys_ready[20]), 1);

        // R8 squash of a landed reuse
        ren(4'd9, 4'd2);
        chk("R2 tag9", 32'(ren_phys), 21);
        chk("R2 prev9", 32'(ren_prev_phys), 9);
        step();
        ren(4'd9, 4'd0);
        chk("R3 reuse9", 32'(ren_reused), 1);
        step();
        wb(5'd21);
        sq_valid = 1; sq_landed = 1; step();
        wb(5'd21);
        chk("R8 pending rebuilt", 32'(phys_ready[21]), 0);
        ren(4'd9, 4'd0);
        chk("R8 reuse again", 32'(ren_reused), 1);
        chk("R8 reuse tag", 32'(ren_phys), 21);
        step();
        wb(5'd21);
        chk("R8 ready at end", 32'(phys_ready[21]), 1);

        // R10 drain the free list, keep a pinned run open on arch 11
        ren(4'd11, 4'd3);
        chk("R2 tag11", 32'(ren_phys), 22);
        step();
        for (int k = 0; k < 11; k++) begin
            ren(4'd10, 4'd0);
            // R7: squashed tags 18 and 19 sit at the tail
            chk(k >= 9 ? "R7 tail order" : "R2 fifo order", 32'(ren_phys),
                (k < 9) ? 32'(23 + k) : 32'(18 + k - 9));
            step();
        end
        src_arch = 4'd10;
        ren(4'd10, 4'd0);
        chk("R10 stall", 32'(ren_stall), 1);
        chk("R10 no ok", 32'(ren_ok), 0);
        step();
        #1;
        chk("R10 map kept", 32'(src_phys), 19);
        ren(4'd11, 4'd0);
        chk("R10 reuse while empty", 32'(ren_ok), 1);
        chk("R10 reuse tag", 32'(ren_phys), 22);
        step();

        // R11 release then reallocate
        rel_valid = 1; rel_phys = 5'd5; step();
        ren(4'd10, 4'd0);
        chk("R11 released tag", 32'(ren_phys), 5);
        chk("R11 ok", 32'(ren_ok), 1);
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule